// File: doc/BRIEF.md
# Serial FIFO Buffer with Hardware Handshake

This block sits between a register bus and a serial transmitter/receiver pair. Each direction has a byte queue of parameterised depth, 16 by default. The bus writes bytes into the transmit queue, and the transmitter pulls them one frame at a time. The receiver pushes each byte it assembles into the receive queue, and the bus pops bytes from there. The block reports how many bytes each queue holds and whether it is full. Each queue can be emptied on its own.

Optional automatic flow control links the queues to the modem handshake lines. The partner's clear-to-send input passes through a two-flop synchroniser. Its synchronised value decides whether the transmitter may start a new frame. The request-to-send output is driven from the free space in the receive queue. With flow control off, request-to-send follows a control bit. Two interrupts compare the queue counts against programmable thresholds, and each can run as a one-cycle pulse or as a held level. A status bit shows the synchronised CTS state, and a sticky flag records that CTS changed since the last status read.

Top module: `sio_buffer_hs`

## Requirements
- R1: Each queue holds up to DEPTH bytes and returns them in write order. `tx_cnt_o` and `rx_cnt_o` give the byte counts, updated on the clock edge of a push or pop. `ser_tx_data_o` and `rx_rdata_o` show the oldest byte.
- R2: `tx_full_o` is high when the transmit queue holds DEPTH bytes. A write to a full transmit queue is dropped and leaves the contents and count unchanged.
- R3: A byte arriving from the receiver at a full receive queue is dropped and sets the sticky `rx_ovr_o` on the next edge. `rx_full_o` reports a full receive queue. A cycle with `stat_rd_i` high clears `rx_ovr_o`.
- R4: `tx_clr_i` empties only the transmit queue, and `rx_clr_i` empties only the receive queue. Each takes effect on the next edge.
- R5: With `afc_en_i` high, `ser_tx_valid_o` is low while synchronised CTS is inactive. A change on `cts_ni` reaches the gate after two clock edges. A byte already taken by the transmitter is not recalled, so gating acts only at frame boundaries. With `afc_en_i` low, CTS has no effect on `ser_tx_valid_o`.
- R6: With `afc_en_i` high, `rts_no` is low (asserted) while the receive queue has at least two free entries, and high otherwise.
- R7: With `afc_en_i` low, `rts_no` equals the inverse of `sw_rts_i`.
- R8: `cts_o` is 1 when synchronised CTS is active (`cts_ni` low), two edges after the input changes.
- R9: `dcts_o` is set on the edge where synchronised CTS changes. It is cleared by a `stat_rd_i` cycle in which no new change arrives.
- R10: The receive condition is `rx_cnt >= rx_trig_i`. With `rx_irq_mode_i`=1 (level), `rx_irq_o` follows the condition. With 0 (pulse), `rx_irq_o` is high for one cycle when the condition becomes true.
- R11: The transmit condition is `tx_cnt <= tx_trig_i`. `tx_irq_mode_i` selects level (1) or pulse (0) in the same way for `tx_irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Bus write to the transmit queue |
| tx_wdata_i | input | W | Byte written |
| rx_rd_i | input | 1 | Bus pop from the receive queue |
| rx_rdata_o | output | W | Oldest received byte |
| ser_tx_valid_o | output | 1 | A byte may start transmission |
| ser_tx_data_o | output | W | Byte offered to the transmitter |
| ser_tx_take_i | input | 1 | Transmitter takes the offered byte |
| des_rx_valid_i | input | 1 | Receiver delivers a byte |
| des_rx_data_i | input | W | Delivered byte |
| afc_en_i | input | 1 | Automatic flow control enable |
| sw_rts_i | input | 1 | Software RTS request (active high) |
| tx_clr_i | input | 1 | Empty the transmit queue |
| rx_clr_i | input | 1 | Empty the receive queue |
| rx_trig_i | input | CNT_W | Receive threshold |
| tx_trig_i | input | CNT_W | Transmit threshold |
| rx_irq_mode_i | input | 1 | 1 level, 0 pulse |
| tx_irq_mode_i | input | 1 | 1 level, 0 pulse |
| stat_rd_i | input | 1 | Status read strobe, clears sticky flags |
| cts_ni | input | 1 | Clear-to-send, active low, asynchronous |
| rts_no | output | 1 | Request-to-send, active low |
| tx_cnt_o | output | CNT_W | Transmit byte count |
| rx_cnt_o | output | CNT_W | Receive byte count |
| tx_full_o | output | 1 | Transmit queue full |
| rx_full_o | output | 1 | Receive queue full |
| rx_ovr_o | output | 1 | Sticky receive overrun |
| cts_o | output | 1 | Synchronised CTS active |
| dcts_o | output | 1 | CTS changed since last status read |
| rx_irq_o | output | 1 | Receive threshold interrupt |
| tx_irq_o | output | 1 | Transmit threshold interrupt |

## Verification
The bench builds the block with its defaults: DEPTH of 16 and 8-bit bytes, so count ports are 5 bits wide. At this depth both queues fill in a handful of writes. That makes the dropped write, the overrun on the seventeenth byte, and the RTS switch at fourteen and fifteen entries cheap to reach. Thresholds of 2 to 4 put both edges of each interrupt condition inside short fill and drain runs.

// File: rtl/sio_hs_pkg.sv
package sio_hs_pkg;
  typedef enum logic {IRQ_PULSE = 1'b0, IRQ_LEVEL = 1'b1} irq_mode_e;
endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> $stable(cnt_q));

  // R4
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/sio_irq_gen.sv
module sio_irq_gen
  import sio_hs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cond_i,
  input  irq_mode_e mode_i,
  output logic      irq_o
);
  logic cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= 1'b0;
    else         cond_q <= cond_i;
  end

  assign irq_o = (mode_i == IRQ_LEVEL) ? cond_i : (cond_i & ~cond_q);

  // R10 R11: pulse mode never holds two cycles
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == IRQ_PULSE && irq_o) |=> !(mode_i == IRQ_PULSE && irq_o));
endmodule

// File: rtl/sio_cts_sync.sv
module sio_cts_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cts_ni,
  input  logic stat_rd_i,
  output logic cts_act_o,
  output logic dcts_o
);
  logic s1_q, s2_q, dcts_q, chg;

  assign chg = s1_q ^ s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      dcts_q <= 1'b0;
    end else begin
      s1_q <= cts_ni;
      s2_q <= s1_q;
      if (chg)            dcts_q <= 1'b1;
      else if (stat_rd_i) dcts_q <= 1'b0;
    end
  end

  assign cts_act_o = ~s2_q;
  assign dcts_o    = dcts_q;

  // R9
  dcts_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cts_act_o) |-> dcts_o);
endmodule

// File: rtl/sio_buffer_hs.sv
module sio_buffer_hs
  import sio_hs_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_wr_i,
  input  logic [W-1:0]     tx_wdata_i,
  input  logic             rx_rd_i,
  output logic [W-1:0]     rx_rdata_o,
  output logic             ser_tx_valid_o,
  output logic [W-1:0]     ser_tx_data_o,
  input  logic             ser_tx_take_i,
  input  logic             des_rx_valid_i,
  input  logic [W-1:0]     des_rx_data_i,
  input  logic             afc_en_i,
  input  logic             sw_rts_i,
  input  logic             tx_clr_i,
  input  logic             rx_clr_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] tx_trig_i,
  input  logic             rx_irq_mode_i,
  input  logic             tx_irq_mode_i,
  input  logic             stat_rd_i,
  input  logic             cts_ni,
  output logic             rts_no,
  output logic [CNT_W-1:0] tx_cnt_o,
  output logic [CNT_W-1:0] rx_cnt_o,
  output logic             tx_full_o,
  output logic             rx_full_o,
  output logic             rx_ovr_o,
  output logic             cts_o,
  output logic             dcts_o,
  output logic             rx_irq_o,
  output logic             tx_irq_o
);
  logic tx_empty, rx_empty, cts_act, ovr_q;

  sio_cts_sync u_cts (
    .clk_i, .rst_ni, .cts_ni, .stat_rd_i,
    .cts_act_o(cts_act), .dcts_o(dcts_o)
  );

  assign ser_tx_valid_o = ~tx_empty & (~afc_en_i | cts_act);

  sio_fifo #(.W(W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(tx_clr_i),
    .push_i(tx_wr_i), .data_i(tx_wdata_i),
    .pop_i(ser_tx_take_i & ser_tx_valid_o), .data_o(ser_tx_data_o),
    .cnt_o(tx_cnt_o), .full_o(tx_full_o), .empty_o(tx_empty)
  );

  sio_fifo #(.W(W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(rx_clr_i),
    .push_i(des_rx_valid_i), .data_i(des_rx_data_i),
    .pop_i(rx_rd_i), .data_o(rx_rdata_o),
    .cnt_o(rx_cnt_o), .full_o(rx_full_o), .empty_o(rx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        ovr_q <= 1'b0;
    else if (des_rx_valid_i && rx_full_o && !rx_clr_i) ovr_q <= 1'b1;
    else if (stat_rd_i)                                 ovr_q <= 1'b0;
  end
  assign rx_ovr_o = ovr_q;

  // at least two free slots keeps the partner sending
  assign rts_no = afc_en_i ? (rx_cnt_o > CNT_W'(DEPTH - 2)) : ~sw_rts_i;
  assign cts_o  = cts_act;

  sio_irq_gen u_rx_irq (
    .clk_i, .rst_ni, .cond_i(rx_cnt_o >= rx_trig_i),
    .mode_i(irq_mode_e'(rx_irq_mode_i)), .irq_o(rx_irq_o)
  );

  sio_irq_gen u_tx_irq (
    .clk_i, .rst_ni, .cond_i(tx_cnt_o <= tx_trig_i),
    .mode_i(irq_mode_e'(tx_irq_mode_i)), .irq_o(tx_irq_o)
  );

  // R5
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (afc_en_i && !cts_act) |-> !ser_tx_valid_o);

  // R6
  rts_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (afc_en_i && rx_cnt_o >= CNT_W'(DEPTH - 1)) |-> rts_no);

  // R3
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (des_rx_valid_i && rx_full_o && !rx_clr_i) |=> rx_ovr_o);

  // R1
  rx_empty_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty |-> (rx_cnt_o == '0));
endmodule

// File: tb/tb_sio_buffer_hs.sv
module tb_sio_buffer_hs;
  localparam int W = 8;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tx_wr_i = 0, rx_rd_i = 0, ser_tx_take_i = 0, des_rx_valid_i = 0;
  logic [W-1:0] tx_wdata_i = '0, des_rx_data_i = '0;
  logic afc_en_i = 0, sw_rts_i = 0, tx_clr_i = 0, rx_clr_i = 0;
  logic [CW-1:0] rx_trig_i = 5'd4, tx_trig_i = 5'd4;
  logic rx_irq_mode_i = 1, tx_irq_mode_i = 1, stat_rd_i = 0, cts_ni = 1;
  logic [W-1:0] rx_rdata_o, ser_tx_data_o;
  logic ser_tx_valid_o, rts_no, tx_full_o, rx_full_o, rx_ovr_o;
  logic cts_o, dcts_o, rx_irq_o, tx_irq_o;
  logic [CW-1:0] tx_cnt_o, rx_cnt_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sio_buffer_hs #(.W(W), .DEPTH(DEPTH)) dut (.*);

  // {data, expected tx count after the push}
  localparam logic [12:0] VEC [8] = '{
    {8'hA5, 5'd1}, {8'h3C, 5'd2}, {8'h00, 5'd3}, {8'hFF, 5'd4},
    {8'h81, 5'd5}, {8'h7E, 5'd6}, {8'h12, 5'd7}, {8'hC9, 5'd8}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic push_tx(input logic [W-1:0] d);
    tx_wr_i = 1; tx_wdata_i = d; tick(); tx_wr_i = 0;
  endtask

  task automatic push_rx(input logic [W-1:0] d);
    des_rx_valid_i = 1; des_rx_data_i = d; tick(); des_rx_valid_i = 0;
  endtask

  task automatic take_tx();
    ser_tx_take_i = 1; tick(); ser_tx_take_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1; tick();
    // reset state
    chk("R1 tx_cnt reset", tx_cnt_o, 0);
    chk("R1 rx_cnt reset", rx_cnt_o, 0);
    chk("R7 rts reset", rts_no, 1);
    chk("R8 cts reset", cts_o, 0);
    chk("R9 dcts reset", dcts_o, 0);

    // vector table: fill then drain, order and counts
    foreach (VEC[i]) begin
      push_tx(VEC[i][12:5]);
      chk("R1 tx_cnt", tx_cnt_o, VEC[i][4:0]);
      chk("R11 tx level", tx_irq_o, (VEC[i][4:0] <= 4));
    end
    chk("R5 afc off ignores cts", ser_tx_valid_o, 1);
    foreach (VEC[i]) begin
      chk("R1 tx order", ser_tx_data_o, VEC[i][12:5]);
      take_tx();
      chk("R11 tx level drain", tx_irq_o, ((7 - i) <= 4));
    end

    // R2: fill, drop the extra write
    for (int i = 0; i < DEPTH + 1; i++) push_tx(8'(8'h20 + i));
    chk("R2 tx full", tx_full_o, 1);
    chk("R2 tx cnt", tx_cnt_o, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 tx data kept", ser_tx_data_o, 8'h20 + i);
      take_tx();
    end
    chk("R2 extra dropped", tx_cnt_o, 0);

    // R4: independent clears
    push_tx(8'h01); push_tx(8'h02); push_rx(8'h03); push_rx(8'h04);
    tx_clr_i = 1; tick(); tx_clr_i = 0;
    chk("R4 tx cleared", tx_cnt_o, 0);
    chk("R4 rx untouched", rx_cnt_o, 2);
    push_tx(8'h05);
    rx_clr_i = 1; tick(); rx_clr_i = 0;
    chk("R4 rx cleared", rx_cnt_o, 0);
    chk("R4 tx untouched", tx_cnt_o, 1);

    // R5 R8 R9: CTS gating, sync delay, delta
    afc_en_i = 1; tick();
    chk("R5 gated cts inactive", ser_tx_valid_o, 0);
    cts_ni = 0; tick();
    chk("R5 one edge still gated", ser_tx_valid_o, 0);
    chk("R8 one edge", cts_o, 0);
    tick();
    chk("R5 open after sync", ser_tx_valid_o, 1);
    chk("R8 cts active", cts_o, 1);
    chk("R9 dcts set", dcts_o, 1);
    stat_rd_i = 1; tick(); stat_rd_i = 0;
    chk("R9 dcts cleared", dcts_o, 0);
    cts_ni = 1; tick(); tick();
    chk("R5 gated again", ser_tx_valid_o, 0);
    chk("R9 dcts on deassert", dcts_o, 1);
    take_tx();
    chk("R5 take ignored while gated", tx_cnt_o, 1);
    stat_rd_i = 1; tick(); stat_rd_i = 0;
    tx_clr_i = 1; tick(); tx_clr_i = 0;

    // R6 R3: RTS from free space, overrun
    chk("R6 rts asserted empty", rts_no, 0);
    for (int i = 0; i < DEPTH - 2; i++) push_rx(8'(8'h40 + i));
    chk("R6 two free", rts_no, 0);
    push_rx(8'h4E);
    chk("R6 one free", rts_no, 1);
    push_rx(8'h4F);
    chk("R3 rx full", rx_full_o, 1);
    chk("R3 no ovr yet", rx_ovr_o, 0);
    push_rx(8'hEE);
    chk("R3 ovr set", rx_ovr_o, 1);
    chk("R3 cnt held", rx_cnt_o, DEPTH);
    chk("R10 rx level", rx_irq_o, 1);
    stat_rd_i = 1; tick(); stat_rd_i = 0;
    chk("R3 ovr cleared", rx_ovr_o, 0);
    afc_en_i = 0; sw_rts_i = 1; tick();
    chk("R7 sw rts on", rts_no, 0);
    sw_rts_i = 0; tick();
    chk("R7 sw rts off", rts_no, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 rx order, extra dropped", rx_rdata_o, 8'h40 + i);
      rx_rd_i = 1; tick(); rx_rd_i = 0;
    end
    chk("R1 rx drained", rx_cnt_o, 0);

    // R10: pulse mode
    rx_irq_mode_i = 0; rx_trig_i = 5'd3; tick();
    push_rx(8'h01); push_rx(8'h02);
    chk("R10 below trig", rx_irq_o, 0);
    push_rx(8'h03);
    chk("R10 pulse", rx_irq_o, 1);
    tick();
    chk("R10 pulse one cycle", rx_irq_o, 0);

    // R11: pulse mode
    tx_irq_mode_i = 0; tx_trig_i = 5'd2; tick();
    push_tx(8'h0A); push_tx(8'h0B); push_tx(8'h0C);
    chk("R11 above trig", tx_irq_o, 0);
    take_tx();
    chk("R11 pulse", tx_irq_o, 1);
    tick();
    chk("R11 pulse one cycle", tx_irq_o, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule